// File: doc/BRIEF.md
# Register Write Protection Wrapper

This block sits in front of a peripheral's register file and guards it against stray writes. A byte-addressed bus request carries an address, four byte enables, 32 bits of write data and a read/write select. The wrapper sorts each request into one area of a fixed map:

- a direct register window;
- a mirror of that window, whose writes also lock every byte they write;
- an array of per-byte soft locks;
- one configuration word holding a sticky hard lock.

Accesses to the register window and to the reserved gap after it are forwarded to the peripheral in the same cycle. The peripheral's read data is sampled in that cycle.

A write that touches any locked byte is refused as a whole and answered with a transfer error. Setting the hard lock freezes every soft lock until reset.

Every accepted request gets a response one cycle later, through a bus response state machine with three states:

- `S_IDLE`: no response is pending.
- `S_OK_RESP`: a good response is pending.
- `S_ERR_RESP`: an error response is pending.

The transitions are:

- *issue_ok*: a request with no error moves to `S_OK_RESP`.
- *issue_err*: a refused or unmapped request moves to `S_ERR_RESP`.
- *drain*: with no request, either response state returns to `S_IDLE`.

Requests may come back to back.

A lock mode state machine holds the hard lock. It has two states, `MODE_OPEN` and `MODE_FROZEN`. The transition *freeze* goes from open to frozen on a configuration write with bit 0 set. Only reset returns it to `MODE_OPEN`.

The window size `WIN_BYTES` is a parameter, a multiple of 16, up to 6144 bytes. The default is 256. The areas sit at these byte offsets:

| Area | Offsets |
|---|---|
| Direct window | `0` to `WIN_BYTES-1` |
| Reserved | `WIN_BYTES` to `0x1FFF` |
| Mirror window | `0x2000` to `0x2000+WIN_BYTES-1` |
| Soft-lock array | `0x3800` to `0x3800+WIN_BYTES/4-1` |
| Configuration word | `0x3FFC` |

Top module: `rwp_wrapper`

## Requirements
- R1: After reset there is no response pending. Every soft lock reads 0, and the configuration word reads 0.
- R2: A direct-window request is forwarded in its own cycle, with the address low two bits forced to 0. The response comes one cycle later with `err_o`=0. Write data lands in the byte lanes whose enables are set (lane b is `wdata_i[8b+7:8b]`). A read returns the peripheral's word.
- R3: A read at `0x2000+Y` returns the same word as a read at Y and changes no lock.
- R4: A write at `0x2000+Y` with no locked byte enabled writes the data as at Y. It also sets the lock of each byte it enables.
- R5: A write to the direct or mirror window that enables at least one locked byte writes no byte and answers `err_o`=1. A write whose enabled bytes are all unlocked succeeds, even when other bytes of the same word are locked.
- R6: Reads of the window are never refused because of locks.
- R7: Soft-lock byte n, bit j (j=0..3) guards register byte 4n+j. Soft-lock byte n sits in lane n mod 4 of the word at `0x3800+4*(n/4)`. In a write to it, bits [7:4] are a mask and bits [3:0] the values. A lock becomes 1 only when its mask bit and value bit are both 1, and a write never clears a lock. Reads return mask bits as 0.
- R8: Writing 1 to bit 0 of the configuration word (lane 0 enabled) sets the hard lock. The hard lock reads back in bit 0 and stays set, whatever is written, until reset.
- R9: While the hard lock is set, soft-lock writes and mirror writes change no lock. Mirror writes still write their data.
- R10: The following are unimplemented. Reads and writes there answer `err_o`=1 with `rdata_o`=0 and are not forwarded.
  - mirror offsets from `0x2000+WIN_BYTES` to `0x37FF`;
  - offsets from `0x3800+WIN_BYTES/4` to `0x3FFB`.
- R11: Offsets from `WIN_BYTES` to `0x1FFF` are forwarded unchecked, with `err_o`=0.
- R12: A lock set by a mirror write already applies to a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Request strobe, one cycle per request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Byte address, low two bits ignored |
| be_i | input | 4 | Byte lane enables |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rdata_o | output | 32 | Read data of the response |
| err_o | output | 1 | Transfer error of the response |
| fwd_valid_o | output | 1 | Forwarded access to the peripheral |
| fwd_we_o | output | 1 | Forwarded write select |
| fwd_addr_o | output | 13 | Forwarded word-aligned address |
| fwd_be_o | output | 4 | Forwarded byte enables |
| fwd_wdata_o | output | 32 | Forwarded write data |
| fwd_rdata_i | input | 32 | Peripheral read data, valid in the request cycle |

## Verification
Two functions can fall in one clock edge: the forwarded data write of a mirror request and the setting of its byte locks. The request that follows then depends on the lock state that edge produced. The bench issues a mirror write and, in the very next cycle, a direct write to a byte it just locked. It expects a good response for the first, an error for the second, and a read-back showing only the first write's data. A second overlap is a write that enables both locked and unlocked bytes of one word. That write is judged refused as a whole, by a read-back showing the unlocked byte unchanged.

// File: rtl/rwp_pkg.sv
package rwp_pkg;

    localparam logic [13:0] MIRROR_BASE = 14'h2000;
    localparam logic [13:0] SLB_BASE    = 14'h3800;
    localparam logic [13:0] CFG_ADDR    = 14'h3FFC;

    typedef enum logic [2:0] {
        AR_DIRECT,
        AR_RSVD,
        AR_MIRROR,
        AR_SLB,
        AR_CFG,
        AR_BAD
    } area_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OK_RESP,
        S_ERR_RESP
    } bus_state_e;

    typedef enum logic {
        MODE_OPEN,
        MODE_FROZEN
    } mode_e;

endpackage

// File: rtl/rwp_decode.sv
module rwp_decode
    import rwp_pkg::*;
#(
    parameter int WIN_BYTES = 256
) (
    input  logic [13:0] addr_i,
    output area_e       area_o
);

    localparam int unsigned WIN_END    = WIN_BYTES;
    localparam int unsigned MIR_START  = 32'(MIRROR_BASE);
    localparam int unsigned MIR_END    = MIR_START + WIN_BYTES;
    localparam int unsigned SLB_START  = 32'(SLB_BASE);
    localparam int unsigned SLB_END    = SLB_START + WIN_BYTES / 4;
    localparam int unsigned CFG_WORD   = 32'(CFG_ADDR);

    logic [31:0] word_addr;

    always_comb begin
        word_addr = {18'd0, addr_i} & 32'hFFFF_FFFC;
        if (word_addr < WIN_END) begin
            area_o = AR_DIRECT;
        end else if (word_addr < MIR_START) begin
            area_o = AR_RSVD;
        end else if (word_addr < MIR_END) begin
            area_o = AR_MIRROR;
        end else if (word_addr >= SLB_START && word_addr < SLB_END) begin
            area_o = AR_SLB;
        end else if (word_addr == CFG_WORD) begin
            area_o = AR_CFG;
        end else begin
            area_o = AR_BAD;
        end
    end

endmodule

// File: rtl/rwp_lock_store.sv
module rwp_lock_store
    import rwp_pkg::*;
#(
    parameter int WIN_BYTES = 256
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(WIN_BYTES/4)-1:0]   look_idx_i,
    output logic [3:0]                       look_lock_o,
    input  logic                             mir_set_i,
    input  logic [3:0]                       mir_be_i,
    input  logic [$clog2(WIN_BYTES/16)-1:0]  slb_idx_i,
    input  logic                             slb_wr_i,
    input  logic [3:0]                       slb_be_i,
    input  logic [31:0]                      slb_wdata_i,
    output logic [31:0]                      slb_rdata_o,
    input  logic                             freeze_i,
    output logic                             hard_o
);

    localparam int LOCK_WORDS = WIN_BYTES / 4;
    localparam int LW         = $clog2(LOCK_WORDS);
    localparam int SW         = $clog2(WIN_BYTES / 16);

    mode_e mode_q, mode_d;
    logic [LOCK_WORDS-1:0][3:0] lock_q, lock_d;

    // Lock mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OPEN;
            lock_q <= '0;
        end else begin
            mode_q <= mode_d;
            lock_q <= lock_d;
        end
    end

    // Lock mode transitions: freeze is one-way
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_OPEN:   if (freeze_i) mode_d = MODE_FROZEN;
            MODE_FROZEN: mode_d = MODE_FROZEN;
            default:     mode_d = MODE_OPEN;
        endcase
    end

    // Lock array update: set-only, gated by mode
    always_comb begin
        lock_d = lock_q;
        if (mode_q == MODE_OPEN) begin
            if (mir_set_i) begin
                lock_d[look_idx_i] = lock_q[look_idx_i] | mir_be_i;
            end
            if (slb_wr_i) begin
                for (int b = 0; b < 4; b++) begin
                    if (slb_be_i[b]) begin
                        lock_d[{slb_idx_i, 2'(b)}] = lock_d[{slb_idx_i, 2'(b)}]
                            | (slb_wdata_i[8*b +: 4] & slb_wdata_i[8*b+4 +: 4]);
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        hard_o      = (mode_q == MODE_FROZEN);
        look_lock_o = lock_q[look_idx_i];
        for (int b = 0; b < 4; b++) begin
            slb_rdata_o[8*b +: 8] = {4'b0000, lock_q[{slb_idx_i, 2'(b)}]};
        end
    end

    AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hard_o |=> hard_o); // R8

    AST_LOCK_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R7

    AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hard_o |=> $stable(lock_q)); // R9

    initial begin
        AST_WIN_MULT16: assert (WIN_BYTES % 16 == 0 && WIN_BYTES >= 16 && WIN_BYTES <= 6144 && LW == SW + 2); // R7
    end

endmodule

// File: rtl/rwp_bus_fsm.sv
module rwp_bus_fsm
    import rwp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        err_i,
    input  logic [31:0] rdata_i,
    output logic        rsp_valid_o,
    output logic        err_o,
    output logic [31:0] rdata_o
);

    bus_state_e state_q, state_d;
    logic [31:0] rdata_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (req_i && !err_i) ? rdata_i : 32'd0;
        end
    end

    // Transitions: issue_ok, issue_err, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_OK_RESP, S_ERR_RESP: begin
                if (!req_i)     state_d = S_IDLE;
                else if (err_i) state_d = S_ERR_RESP;
                else            state_d = S_OK_RESP;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rsp_valid_o = (state_q != S_IDLE);
        err_o       = (state_q == S_ERR_RESP);
        rdata_o     = rdata_q;
    end

endmodule

// File: rtl/rwp_wrapper.sv
module rwp_wrapper
    import rwp_pkg::*;
#(
    parameter int WIN_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [13:0] addr_i,
    input  logic [3:0]  be_i,
    input  logic [31:0] wdata_i,
    output logic        rsp_valid_o,
    output logic [31:0] rdata_o,
    output logic        err_o,
    output logic        fwd_valid_o,
    output logic        fwd_we_o,
    output logic [12:0] fwd_addr_o,
    output logic [3:0]  fwd_be_o,
    output logic [31:0] fwd_wdata_o,
    input  logic [31:0] fwd_rdata_i
);

    localparam int LW = $clog2(WIN_BYTES / 4);
    localparam int SW = $clog2(WIN_BYTES / 16);

    area_e        area;
    logic [3:0]   look_lock;
    logic [31:0]  slb_rdata;
    logic         hard;
    logic         hit_locked;
    logic         mir_set, slb_wr, freeze;
    logic         err_n;
    logic [31:0]  rdata_n;

    rwp_decode #(.WIN_BYTES(WIN_BYTES)) u_decode (
        .addr_i (addr_i),
        .area_o (area)
    );

    rwp_lock_store #(.WIN_BYTES(WIN_BYTES)) u_locks (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_idx_i  (addr_i[LW+1:2]),
        .look_lock_o (look_lock),
        .mir_set_i   (mir_set),
        .mir_be_i    (be_i),
        .slb_idx_i   (addr_i[SW+1:2]),
        .slb_wr_i    (slb_wr),
        .slb_be_i    (be_i),
        .slb_wdata_i (wdata_i),
        .slb_rdata_o (slb_rdata),
        .freeze_i    (freeze),
        .hard_o      (hard)
    );

    // Area handling for the current request
    always_comb begin
        hit_locked  = |(be_i & look_lock);
        fwd_valid_o = 1'b0;
        mir_set     = 1'b0;
        slb_wr      = 1'b0;
        freeze      = 1'b0;
        err_n       = 1'b0;
        rdata_n     = 32'd0;
        if (req_i) begin
            unique case (area)
                AR_DIRECT, AR_MIRROR: begin
                    if (we_i && hit_locked) begin
                        err_n = 1'b1;
                    end else begin
                        fwd_valid_o = 1'b1;
                        mir_set     = we_i && (area == AR_MIRROR);
                        rdata_n     = we_i ? 32'd0 : fwd_rdata_i;
                    end
                end
                AR_RSVD: begin
                    fwd_valid_o = 1'b1;
                    rdata_n     = we_i ? 32'd0 : fwd_rdata_i;
                end
                AR_SLB: begin
                    slb_wr  = we_i;
                    rdata_n = we_i ? 32'd0 : slb_rdata;
                end
                AR_CFG: begin
                    freeze  = we_i && be_i[0] && wdata_i[0];
                    rdata_n = we_i ? 32'd0 : {31'd0, hard};
                end
                AR_BAD: begin
                    err_n = 1'b1;
                end
                default: err_n = 1'b1;
            endcase
        end
    end

    always_comb begin
        fwd_we_o    = we_i;
        fwd_addr_o  = {addr_i[12:2], 2'b00};
        fwd_be_o    = be_i;
        fwd_wdata_o = wdata_i;
    end

    rwp_bus_fsm u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .err_i       (err_n),
        .rdata_i     (rdata_n),
        .rsp_valid_o (rsp_valid_o),
        .err_o       (err_o),
        .rdata_o     (rdata_o)
    );

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_i)); // R2

    AST_FWD_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && fwd_we_o) |=> (rsp_valid_o && !err_o)); // R5

    AST_BAD_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && area == AR_BAD) |-> !fwd_valid_o); // R10

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == 32'd0)); // R10

endmodule

// File: tb/test_rwp_wrapper.sv
module test_rwp_wrapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [13:0] addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        rsp_valid, err, fwd_valid, fwd_we;
    logic [31:0] rdata, fwd_wdata, fwd_rdata;
    logic [12:0] fwd_addr;
    logic [3:0]  fwd_be;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    rwp_wrapper #(.WIN_BYTES(256)) i_rwp_wrapper (
        .clk (clk), .rst_n (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
        .be_i (be), .wdata_i (wdata), .rsp_valid_o (rsp_valid), .rdata_o (rdata),
        .err_o (err), .fwd_valid_o (fwd_valid), .fwd_we_o (fwd_we),
        .fwd_addr_o (fwd_addr), .fwd_be_o (fwd_be), .fwd_wdata_o (fwd_wdata),
        .fwd_rdata_i (fwd_rdata)
    );

    // Peripheral model: 512 bytes, asynchronous read
    logic [7:0] mem [0:511];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'h00;
        end else if (fwd_valid && fwd_we) begin
            for (int b = 0; b < 4; b++)
                if (fwd_be[b]) mem[{fwd_addr[8:2], 2'(b)}] <= fwd_wdata[8*b +: 8];
        end
    end
    always_comb begin
        for (int b = 0; b < 4; b++) fwd_rdata[8*b +: 8] = mem[{fwd_addr[8:2], 2'(b)}];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request; starts and ends at a falling edge
    task automatic acc(input logic w, input logic [13:0] a, input logic [3:0] e,
                       input logic [31:0] d, output logic [31:0] rd,
                       output logic er, output logic fv);
        req = 1'b1; we = w; addr = a; be = e; wdata = d;
        #1 fv = fwd_valid;
        @(negedge clk);
        rd = rdata; er = err;
        if (!rsp_valid) chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [13:0] a,
                          input logic [31:0] exp, input logic exp_err);
        logic [31:0] r; logic e, f;
        acc(1'b0, a, 4'hF, 32'd0, r, e, f);
        chk(tag, r, exp);
        chk({tag, " err"}, {31'd0, e}, {31'd0, exp_err});
    endtask

    task automatic wr_chk(input string tag, input logic [13:0] a, input logic [3:0] e,
                          input logic [31:0] d, input logic exp_err);
        logic [31:0] r; logic er, f;
        acc(1'b1, a, e, d, r, er, f);
        chk({tag, " err"}, {31'd0, er}, {31'd0, exp_err});
    endtask

    task automatic t_reset;
        chk("R1 no response", {31'd0, rsp_valid}, 32'd0);
        rd_chk("R1 lock array", 14'h3800, 32'd0, 1'b0);
        rd_chk("R1 cfg word", 14'h3FFC, 32'd0, 1'b0);
    endtask

    task automatic t_direct;
        logic [31:0] r; logic e, f;
        acc(1'b1, 14'h0010, 4'hF, 32'hA1B2C3D4, r, e, f);
        chk("R2 fwd write", {31'd0, f}, 32'd1);
        chk("R2 write err", {31'd0, e}, 32'd0);
        rd_chk("R2 readback", 14'h0010, 32'hA1B2C3D4, 1'b0);
        wr_chk("R2 lane write", 14'h0012, 4'h3, 32'h00005566, 1'b0);
        rd_chk("R2 lanes", 14'h0010, 32'hA1B25566, 1'b0);
    endtask

    task automatic t_mirror_read;
        rd_chk("R3 mirror read", 14'h2010, 32'hA1B25566, 1'b0);
        rd_chk("R3 no lock", 14'h3804, 32'd0, 1'b0);
    endtask

    task automatic t_mirror_write;
        wr_chk("R4 mirror write", 14'h2020, 4'h5, 32'h11223344, 1'b0);
        rd_chk("R4 data", 14'h0020, 32'h00220044, 1'b0);
        rd_chk("R4 locks", 14'h3808, 32'h00000005, 1'b0);
    endtask

    task automatic t_partial;
        wr_chk("R5 unlocked lane", 14'h0020, 4'h2, 32'h0000AA00, 1'b0);
        rd_chk("R5 unlocked data", 14'h0020, 32'h0022AA44, 1'b0);
        wr_chk("R5 mixed write", 14'h0020, 4'h3, 32'hFFFFFFFF, 1'b1);
        wr_chk("R5 mirror locked", 14'h2020, 4'h1, 32'hFFFFFFFF, 1'b1);
        rd_chk("R5 data kept", 14'h0020, 32'h0022AA44, 1'b0);
        rd_chk("R6 mirror read locked", 14'h2020, 32'h0022AA44, 1'b0);
    endtask

    task automatic t_slb;
        wr_chk("R7 set", 14'h380C, 4'h1, 32'h000000F3, 1'b0);
        wr_chk("R7 no clear", 14'h380C, 4'h1, 32'h000000C0, 1'b0);
        wr_chk("R7 masked", 14'h380C, 4'h1, 32'h00000048, 1'b0);
        rd_chk("R7 after mask", 14'h380C, 32'h00000003, 1'b0);
        wr_chk("R7 bit2", 14'h380C, 4'h1, 32'h00000044, 1'b0);
        wr_chk("R7 lane1", 14'h380C, 4'h2, 32'h00001100, 1'b0);
        rd_chk("R7 readback", 14'h380C, 32'h00000107, 1'b0);
        wr_chk("R7 byte3 free", 14'h0030, 4'h8, 32'h77000000, 1'b0);
        wr_chk("R7 byte2 locked", 14'h0030, 4'h4, 32'h00660000, 1'b1);
        rd_chk("R7 word12", 14'h0030, 32'h77000000, 1'b0);
        wr_chk("R7 word13 byte0", 14'h0034, 4'h1, 32'h00000011, 1'b1);
    endtask

    task automatic t_reserved;
        logic [31:0] r; logic e, f;
        acc(1'b1, 14'h0100, 4'hF, 32'hCAFEF00D, r, e, f);
        chk("R11 fwd", {31'd0, f}, 32'd1);
        chk("R11 err", {31'd0, e}, 32'd0);
        rd_chk("R11 readback", 14'h0100, 32'hCAFEF00D, 1'b0);
    endtask

    task automatic t_bad;
        logic [31:0] r; logic e, f;
        acc(1'b0, 14'h3840, 4'hF, 32'd0, r, e, f);
        chk("R10 read err", {31'd0, e}, 32'd1);
        chk("R10 read data", r, 32'd0);
        chk("R10 no fwd", {31'd0, f}, 32'd0);
        acc(1'b1, 14'h3FF8, 4'hF, 32'hFFFFFFFF, r, e, f);
        chk("R10 write err", {31'd0, e}, 32'd1);
        acc(1'b1, 14'h2100, 4'hF, 32'h12345678, r, e, f);
        chk("R10 mirror beyond err", {31'd0, e}, 32'd1);
        chk("R10 mirror beyond no fwd", {31'd0, f}, 32'd0);
        rd_chk("R10 reserved kept", 14'h0100, 32'hCAFEF00D, 1'b0);
    endtask

    task automatic t_back2back;
        req = 1'b1; we = 1'b1; addr = 14'h2040; be = 4'hF; wdata = 32'h01020304;
        @(negedge clk);
        chk("R12 first ok", {31'd0, err}, 32'd0);
        addr = 14'h0040; be = 4'h1; wdata = 32'h000000FF;
        @(negedge clk);
        chk("R12 second refused", {31'd0, err}, 32'd1);
        chk("R12 second valid", {31'd0, rsp_valid}, 32'd1);
        req = 1'b0; we = 1'b0;
        rd_chk("R12 data", 14'h0040, 32'h01020304, 1'b0);
    endtask

    task automatic t_hard;
        wr_chk("R8 set", 14'h3FFC, 4'h1, 32'h00000001, 1'b0);
        rd_chk("R8 read", 14'h3FFC, 32'h00000001, 1'b0);
        wr_chk("R8 clear try", 14'h3FFC, 4'hF, 32'h00000000, 1'b0);
        rd_chk("R8 sticky", 14'h3FFC, 32'h00000001, 1'b0);
        wr_chk("R9 slb write", 14'h3810, 4'h2, 32'h0000FF00, 1'b0);
        rd_chk("R9 slb frozen", 14'h3810, 32'h0000000F, 1'b0);
        wr_chk("R9 mirror write", 14'h2050, 4'hF, 32'h55667788, 1'b0);
        rd_chk("R9 mirror data", 14'h0050, 32'h55667788, 1'b0);
        rd_chk("R9 no new lock", 14'h3814, 32'd0, 1'b0);
        wr_chk("R9 still writable", 14'h0050, 4'h1, 32'h000000AB, 1'b0);
        rd_chk("R9 old locks", 14'h3808, 32'h00000005, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_mirror_read();
        t_mirror_write();
        t_partial();
        t_slb();
        t_reserved();
        t_bad();
        t_back2back();
        t_hard();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule